// File: doc/BRIEF.md
# Routed Multi-Output Combinational ALU

This block is a purely combinational arithmetic and logic unit with no clock and no reset. It takes a 16-bit instruction word and two 8-bit operands. Three select fields in the instruction choose one result: a shift, an add or subtract, a bitwise operation, a constant, or a corner-bit match test. A fourth field sends that result to one of four 8-bit output ports. The ports that are not chosen drive zero.

Two flags come out beside the data. The overflow flag is the carry out of the unsigned sum, and it is live only while the unit is adding. The zero flag reports whether the routed result is zero. Instruction bits [7:0] hold the four 2-bit select fields. Bits [15:8] play no part.

Top module: `route_alu`

## Requirements
- R1: The destination field instr_word[1:0] routes the result: 0 to port0, 1 to port1, 2 to port2 and 3 to port3.
- R2: Every output port that the destination field does not name drives 0.
- R3: The category field instr_word[3:2] picks the result: 0 takes the arithmetic result, 1 the logical result, 2 the constant 0 and 3 the corner-match result.
- R4: Arithmetic field instr_word[5:4] = 0 gives opnd_a shifted right by opnd_b. A value of 1 gives opnd_a shifted left by opnd_b, keeping the low 8 bits. For either shift, an amount of 8 or more gives 0.
- R5: Arithmetic field value 2 gives opnd_a + opnd_b and value 3 gives opnd_a - opnd_b, both taken modulo 256.
- R6: Logical field instr_word[7:6] gives bitwise AND for 0, OR for 1, XOR for 2 and the constant 1 for 3.
- R7: The corner-match result is 1 when opnd_a[0], opnd_a[7], opnd_b[0] and opnd_b[7] all hold the same value, and 0 otherwise.
- R8: ovf_flag is the carry out of the 8-bit unsigned sum. It is asserted only when the category is arithmetic and the arithmetic field selects addition; otherwise it is 0.
- R9: zero_flag is 1 exactly when the routed result equals 0.
- R10: Bits instr_word[15:8] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Instruction word holding the four select fields |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand, also the shift amount |
| port0 | output | 8 | Output channel 0 |
| port1 | output | 8 | Output channel 1 |
| port2 | output | 8 | Output channel 2 |
| port3 | output | 8 | Output channel 3 |
| ovf_flag | output | 1 | Unsigned carry out of the addition |
| zero_flag | output | 1 | The routed result is zero |

## Verification
The bench crosses all 256 low instruction bytes with operand pairs chosen to reach the edges of each operation:
- Shift amounts of 7, 8 and 255 check the saturation to zero. A design that used only the low three bits of the amount would wrap instead of clearing.
- Sums that cross 255 and differences that go below zero check the carry and the modulo-256 wrap. A design with a leaky flag would raise overflow on subtraction, on a shift, or while the result goes to a non-arithmetic category.
- Operands whose corner bits differ in a single position test the match operation. A design that compared only one operand would answer 1 where it should answer 0.
- Random upper instruction bytes check R10. A decoder that took a field from the wrong bits would change the outputs.

// File: rtl/route_alu_pkg.sv
package route_alu_pkg;

  // Category select encodings
  typedef enum logic [1:0] {
    CAT_ARITH = 2'd0,
    CAT_LOGIC = 2'd1,
    CAT_ZERO  = 2'd2,
    CAT_MATCH = 2'd3
  } cat_sel_e;

  // Arithmetic select encodings
  typedef enum logic [1:0] {
    AR_SHR = 2'd0,
    AR_SHL = 2'd1,
    AR_ADD = 2'd2,
    AR_SUB = 2'd3
  } arith_sel_e;

  // Logical select encodings
  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_ONE = 2'd3
  } logic_sel_e;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned DEST_LSB  = 0;
  localparam int unsigned CAT_LSB   = 2;
  localparam int unsigned ARITH_LSB = 4;
  localparam int unsigned LOGIC_LSB = 6;
  localparam int unsigned USED_BITS = 8;

endpackage

// File: rtl/route_alu_arith.sv
module route_alu_arith
  import route_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  arith_sel_e        sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              shift_sat_o
);

  localparam logic [DATA_W-1:0] SAT_LIMIT = DATA_W[DATA_W-1:0];

  function automatic logic [DATA_W-1:0] shr_sat(input logic [DATA_W-1:0] v,
                                                input logic [DATA_W-1:0] amt);
    if (amt >= SAT_LIMIT) return '0;
    return v >> amt;
  endfunction

  function automatic logic [DATA_W-1:0] shl_sat(input logic [DATA_W-1:0] v,
                                                input logic [DATA_W-1:0] amt);
    if (amt >= SAT_LIMIT) return '0;
    return v << amt;
  endfunction

  function automatic logic [DATA_W:0] add_wide(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [DATA_W-1:0] sub_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x - y;
  endfunction

  logic [DATA_W:0]   sum_w;
  logic [DATA_W-1:0] shr_w;
  logic [DATA_W-1:0] shl_w;
  logic [DATA_W-1:0] dif_w;

  assign sum_w       = add_wide(a_i, b_i);
  assign shr_w       = shr_sat(a_i, b_i);
  assign shl_w       = shl_sat(a_i, b_i);
  assign dif_w       = sub_wrap(a_i, b_i);
  assign shift_sat_o = (b_i >= SAT_LIMIT);

  always_comb begin
    unique case (sel_i)
      AR_SHR:  res_o = shr_w;
      AR_SHL:  res_o = shl_w;
      AR_ADD:  res_o = sum_w[DATA_W-1:0];
      default: res_o = dif_w;
    endcase
    carry_o = (sel_i == AR_ADD) ? sum_w[DATA_W] : 1'b0;
  end

  always_comb begin
    // R4
    shift_zero_chk: assert (!(shift_sat_o && (sel_i == AR_SHR || sel_i == AR_SHL)) || res_o == '0)
      else $error("saturated shift produced nonzero");
    // R8
    carry_src_chk: assert (!carry_o || sel_i == AR_ADD)
      else $error("carry raised outside addition");
  end

endmodule

// File: rtl/route_alu_logic.sv
module route_alu_logic
  import route_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] res_o
);

  localparam logic [DATA_W-1:0] ONE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ONE_VAL;
    endcase
  end

  always_comb begin
    // R6
    and_subset_chk: assert (sel_i != LG_AND || (res_o & ~a_i) == '0)
      else $error("AND result has a bit outside operand a");
  end

endmodule

// File: rtl/route_alu_demux.sv
module route_alu_demux #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic [DATA_W-1:0]                 val_i,
  input  logic [IDX_W-1:0]                  dest_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] ports_o
);

  logic [NUM_PORTS-1:0] port_nz;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign ports_o[p] = (dest_i == p[IDX_W-1:0]) ? val_i : '0;
    assign port_nz[p] = |ports_o[p];
  end

  always_comb begin
    // R2
    single_port_chk: assert ($countones(port_nz) <= 1)
      else $error("more than one port carries data");
  end

endmodule

// File: rtl/route_alu.sv
module route_alu
  import route_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic [DATA_W-1:0]  port0,
  output logic [DATA_W-1:0]  port1,
  output logic [DATA_W-1:0]  port2,
  output logic [DATA_W-1:0]  port3,
  output logic               ovf_flag,
  output logic               zero_flag
);

  localparam int unsigned NUM_PORTS = 4;
  localparam logic [DATA_W-1:0] ONE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic corner_match(input logic [DATA_W-1:0] x,
                                        input logic [DATA_W-1:0] y);
    logic [3:0] c;
    c = {x[0], x[DATA_W-1], y[0], y[DATA_W-1]};
    return (c == 4'b0000) || (c == 4'b1111);
  endfunction

  logic [SEL_W-1:0] dest_sel;
  cat_sel_e         cat_sel;
  arith_sel_e       ar_sel;
  logic_sel_e       lg_sel;
  logic             unused_hi;

  assign dest_sel  = instr_word[DEST_LSB +: SEL_W];
  assign cat_sel   = cat_sel_e'(instr_word[CAT_LSB +: SEL_W]);
  assign ar_sel    = arith_sel_e'(instr_word[ARITH_LSB +: SEL_W]);
  assign lg_sel    = logic_sel_e'(instr_word[LOGIC_LSB +: SEL_W]);
  assign unused_hi = ^instr_word[INSTR_W-1:USED_BITS];

  logic [DATA_W-1:0] ar_res;
  logic [DATA_W-1:0] lg_res;
  logic              ar_carry;
  logic              ar_sat;
  logic              match_hit;
  logic [DATA_W-1:0] routed;

  route_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i        (opnd_a),
    .b_i        (opnd_b),
    .sel_i      (ar_sel),
    .res_o      (ar_res),
    .carry_o    (ar_carry),
    .shift_sat_o(ar_sat)
  );

  route_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .sel_i(lg_sel),
    .res_o(lg_res)
  );

  assign match_hit = corner_match(opnd_a, opnd_b);

  always_comb begin
    unique case (cat_sel)
      CAT_ARITH: routed = ar_res;
      CAT_LOGIC: routed = lg_res;
      CAT_ZERO:  routed = '0;
      default:   routed = match_hit ? ONE_VAL : '0;
    endcase
  end

  logic [NUM_PORTS-1:0][DATA_W-1:0] port_bus;

  route_alu_demux #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_demux (
    .val_i  (routed),
    .dest_i (dest_sel),
    .ports_o(port_bus)
  );

  assign port0     = port_bus[0];
  assign port1     = port_bus[1];
  assign port2     = port_bus[2];
  assign port3     = port_bus[3];
  assign ovf_flag  = (cat_sel == CAT_ARITH) ? ar_carry : 1'b0;
  assign zero_flag = (routed == '0);

  always_comb begin
    // R9
    zero_port_chk: assert (zero_flag == ((port0 | port1 | port2 | port3) == '0))
      else $error("zero flag disagrees with ports");
    // R8
    ovf_scope_chk: assert (!ovf_flag || (cat_sel == CAT_ARITH && ar_sel == AR_ADD))
      else $error("overflow outside arithmetic addition");
    // R3
    const_zero_chk: assert (cat_sel != CAT_ZERO || zero_flag)
      else $error("constant zero category not zero");
    // R4
    sat_route_chk: assert (!(cat_sel == CAT_ARITH && ar_sat && ar_sel != AR_ADD && ar_sel != AR_SUB) || zero_flag)
      else $error("saturated shift routed nonzero");
  end

endmodule

// File: tb/route_alu_bench.sv
module route_alu_bench;

  logic        clk = 1'b0;
  logic [15:0] instr_word;
  logic [7:0]  opnd_a, opnd_b;
  logic [7:0]  port0, port1, port2, port3;
  logic        ovf_flag, zero_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  route_alu u_route_alu (
    .instr_word(instr_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .port0(port0), .port1(port1), .port2(port2), .port3(port3),
    .ovf_flag(ovf_flag), .zero_flag(zero_flag)
  );

  function automatic int model_val(int ins, int a, int b);
    int cat = (ins >> 2) & 3;
    int ar  = (ins >> 4) & 3;
    int lg  = (ins >> 6) & 3;
    if (cat == 0) begin
      if (ar == 0) return (b >= 8) ? 0 : (a / (1 << b));
      if (ar == 1) return (b >= 8) ? 0 : ((a * (1 << b)) % 256);
      if (ar == 2) return (a + b) % 256;
      return (a - b + 256) % 256;
    end
    if (cat == 1) begin
      if (lg == 0) return a & b;
      if (lg == 1) return a | b;
      if (lg == 2) return a ^ b;
      return 1;
    end
    if (cat == 2) return 0;
    begin
      int s = (a & 1) + ((a >> 7) & 1) + (b & 1) + ((b >> 7) & 1);
      return (s == 0 || s == 4) ? 1 : 0;
    end
  endfunction

  function automatic string tag_of(int ins);
    int cat = (ins >> 2) & 3;
    int ar  = (ins >> 4) & 3;
    if (cat == 0) return (ar < 2) ? "R4" : "R5";
    if (cat == 1) return "R6";
    if (cat == 2) return "R3";
    return "R7";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (instr=%h a=%0d b=%0d)",
               tag, what, act, exp, instr_word, opnd_a, opnd_b);
    end
  endtask

  task automatic full_check(string res_tag);
    int ins  = int'(instr_word[7:0]);
    int a    = int'(opnd_a);
    int b    = int'(opnd_b);
    int v    = model_val(ins, a, b);
    int dest = ins & 3;
    int ov   = (((ins >> 2) & 3) == 0 && ((ins >> 4) & 3) == 2 && (a + b) > 255) ? 1 : 0;
    int outs[4];
    outs[0] = int'(port0); outs[1] = int'(port1);
    outs[2] = int'(port2); outs[3] = int'(port3);
    for (int p = 0; p < 4; p++) begin
      if (p == dest) check(res_tag, $sformatf("port%0d", p), outs[p], v);
      else           check("R2", $sformatf("idle port%0d", p), outs[p], 0);
    end
    check("R8", "ovf_flag", int'(ovf_flag), ov);
    check("R9", "zero_flag", int'(zero_flag), (v == 0) ? 1 : 0);
  endtask

  task automatic apply(logic [15:0] ins, logic [7:0] a, logic [7:0] b);
    @(posedge clk);
    instr_word <= ins;
    opnd_a     <= a;
    opnd_b     <= b;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] pa [12] = '{8'd0, 8'd255, 8'd200, 8'd1, 8'd129, 8'd128, 8'd75, 8'd3, 8'd254, 8'd127, 8'd0, 8'd170};
    logic [7:0] pb [12] = '{8'd0, 8'd255, 8'd100, 8'd7, 8'd8, 8'd1, 8'd25, 8'd9, 8'd2, 8'd129, 8'd1, 8'd85};
    instr_word = '0; opnd_a = '0; opnd_b = '0;
    @(negedge clk);
    // reset-like idle state: all-zero instruction and operands
    check("R9", "idle zero_flag", int'(zero_flag), 1);
    check("R2", "idle ports", int'(port0 | port1 | port2 | port3), 0);

    // R1: constant 1 routed to each destination in turn
    for (int d = 0; d < 4; d++) begin
      apply(16'((3 << 6) | (1 << 2) | d), 8'd9, 8'd9);
      check("R1", $sformatf("dest %0d value", d),
            int'(d == 0 ? port0 : d == 1 ? port1 : d == 2 ? port2 : port3), 1);
      full_check("R1");
    end

    // Sweep of every select combination against the operand set
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 12; k++) begin
        apply(16'(i), pa[k], pb[k]);
        full_check(tag_of(i));
      end
    end

    // R10: random upper bits must not alter anything
    for (int i = 0; i < 256; i++) begin
      logic [7:0] hi = 8'($urandom_range(1, 255));
      apply({hi, 8'(i)}, 8'($urandom), 8'($urandom_range(0, 12)));
      full_check("R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule